// File: doc/BRIEF.md
# Conversion Sequencer for a Successive-Approximation ADC

This block is the digital controller in front of an analog successive-approximation converter core. Software writes a control word that holds a 5-bit channel code and a repeat bit. Each such write starts work on the chosen input. The block raises the core's power enable, then gives a one-clock start strobe, and waits for the core's done strobe. It then captures the result and raises a completion flag.

With the repeat bit clear, one conversion runs and the core is powered down as soon as it finishes. With the repeat bit set, the next conversion starts straight after each done. The all-ones channel code is a shutdown command. It powers the core off, cancels repeating mode, and starts nothing further. A write that arrives while a conversion is running abandons that conversion and starts over with the new settings. The latched channel code is also decoded into a class: external input, bandgap, high reference, low reference, reserved, unused or off.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset: `core_pwr_en`=0, `core_start`=0, `conv_flag`=0, `result`=0, `core_chan`=5'h1F, and `chan_kind`=6 (off).
- R2: A write whose channel code is not all ones sets `core_pwr_en` from the clock after the write edge. One clock later `core_start` is high for exactly one clock, with `core_chan` equal to the written code.
- R3: With the repeat bit 0, one conversion runs per write. On the edge that accepts `core_done`, `core_pwr_en` falls and no further start follows.
- R4: With the repeat bit 1, the edge that accepts `core_done` issues the next `core_start` at once, and `core_pwr_en` stays high.
- R5: A write of channel 5'h1F drops `core_pwr_en` on the next edge and cancels repeating mode. No start follows it.
- R6: An accepted `core_done` (core powered, not in the start clock, no write in the same clock) loads `core_data` into `result` and sets `conv_flag`. `result` holds until the next accepted done.
- R7: A write or a `rd_result` pulse clears `conv_flag`, and `result` keeps its value. If a read and an accepted done fall in the same clock, the flag is set.
- R8: A write during a conversion abandons that conversion. Power stays on, a new start follows two clocks later on the new channel, and the next result comes from the new conversion.
- R9: A `core_done` that arrives while no conversion is being awaited (idle, power-up clock or start clock) changes neither `result` nor `conv_flag`.
- R10: `chan_kind` decodes `core_chan` as follows. Codes 0–5 give 0 (external input). 26 gives 1 (bandgap), 29 gives 2 (high reference) and 30 gives 3 (low reference). 27 and 28 give 4 (reserved), 31 gives 6 (off), and every other code gives 5 (unused). Reserved and unused codes still run a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_chan | input | 5 | Channel code carried by the write |
| wr_cont | input | 1 | Repeat bit carried by the write |
| rd_result | input | 1 | Result read strobe, clears the flag |
| core_done | input | 1 | Conversion done strobe from the core |
| core_data | input | 10 | Conversion value from the core |
| core_pwr_en | output | 1 | Power enable to the core |
| core_start | output | 1 | One-clock start strobe to the core |
| core_chan | output | 5 | Channel code driven to the core |
| result | output | 10 | Last captured conversion value |
| conv_flag | output | 1 | Conversion-complete flag |
| chan_kind | output | 3 | Class of the latched channel code |

## Verification
A single-shot conversion is run on all 32 channel codes. This separates each decoded class and shows that reserved and unused codes still convert while only the all-ones code stays silent. Repeating runs show the back-to-back restart timing. Repeating runs are also stopped in two ways: by a shutdown write, which must leave no trailing start, and by a single-shot write, which must finish exactly one more conversion on the new channel. Separate patterns place a read and a done in the same clock, place an injected done in the idle state, and place a done in the power-up clock of an aborted conversion. These tell apart the flag priority, the ignored-done rule and the abort rule.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes: consumers import it by name; no parameters live here.
package adc_seq_pkg;

    // Sequencer states: powered down, power-up settling clock, converting.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PWRUP = 2'd1,
        ST_CONV  = 2'd2
    } seq_state_t;

    // Class of a channel code as seen on the chan_kind port.
    typedef enum logic [2:0] {
        KIND_EXT     = 3'd0,
        KIND_BANDGAP = 3'd1,
        KIND_VREFH   = 3'd2,
        KIND_VREFL   = 3'd3,
        KIND_RSVD    = 3'd4,
        KIND_UNUSED  = 3'd5,
        KIND_OFF     = 3'd6
    } chan_kind_t;

endpackage

// File: rtl/adc_chan_decode.sv
// Module: adc_chan_decode
// Classifies a channel code into external input, internal reference,
// reserved, unused or the all-ones shutdown code.
// Assumes: the reference and reserved codes are distinct and below all ones.
module adc_chan_decode
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W  = 5,
    parameter int NUM_EXT = 6,
    parameter int BG_CODE = 26,
    parameter int VH_CODE = 29,
    parameter int VL_CODE = 30,
    parameter int RSV_LO  = 27,
    parameter int RSV_HI  = 28
) (
    input  logic [CHAN_W-1:0] code,
    output chan_kind_t        kind,
    output logic              is_off
);
    localparam logic [CHAN_W-1:0] OFF_CODE = {CHAN_W{1'b1}};
    localparam logic [CHAN_W-1:0] BG_C     = CHAN_W'(BG_CODE);
    localparam logic [CHAN_W-1:0] VH_C     = CHAN_W'(VH_CODE);
    localparam logic [CHAN_W-1:0] VL_C     = CHAN_W'(VL_CODE);
    localparam logic [CHAN_W-1:0] RSV_LO_C = CHAN_W'(RSV_LO);
    localparam logic [CHAN_W-1:0] RSV_HI_C = CHAN_W'(RSV_HI);
    localparam logic [CHAN_W-1:0] EXT_LIM  = CHAN_W'(NUM_EXT);

    // Priority decode of the code into its class.
    always_comb begin
        is_off = (code == OFF_CODE);
        if (is_off)                                 kind = KIND_OFF;
        else if (code < EXT_LIM)                    kind = KIND_EXT;
        else if (code == BG_C)                      kind = KIND_BANDGAP;
        else if (code == VH_C)                      kind = KIND_VREFH;
        else if (code == VL_C)                      kind = KIND_VREFL;
        else if (code >= RSV_LO_C && code <= RSV_HI_C) kind = KIND_RSVD;
        else                                        kind = KIND_UNUSED;
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Module: adc_seq_fsm
// Power and start sequencing for the converter core. A write powers the
// core, waits one clock, then pulses start. A done in the converting state
// either powers down (single) or restarts (repeat). A write always wins and
// aborts; a shutdown write returns to idle and clears the repeat mode.
// Assumes: done is ignored in the start clock and outside the converting state.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_off,
    input  logic       wr_cont,
    input  logic       done,
    output logic       pwr_en,
    output logic       start,
    output logic       accept,
    output seq_state_t state,
    output logic       cont
);
    seq_state_t state_q;
    logic       start_q;
    logic       cont_q;

    // Done counts only while waiting on a conversion and with no write.
    assign accept = done && (state_q == ST_CONV) && !start_q && !wr_en;

    // State, repeat mode and start strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            cont_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_en) begin
                if (wr_off) begin
                    state_q <= ST_IDLE;
                    cont_q  <= 1'b0;
                end else begin
                    state_q <= ST_PWRUP;
                    cont_q  <= wr_cont;
                end
            end else begin
                case (state_q)
                    ST_PWRUP: begin
                        state_q <= ST_CONV;
                        start_q <= 1'b1;
                    end
                    ST_CONV: begin
                        if (accept) begin
                            if (cont_q) start_q <= 1'b1;
                            else        state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Power is on in every state but idle.
    assign pwr_en = (state_q != ST_IDLE);
    assign start  = start_q;
    assign state  = state_q;
    assign cont   = cont_q;
endmodule

// File: rtl/adc_result_reg.sv
// Module: adc_result_reg
// Holds the last conversion value and the completion flag.
// Assumes: accept is never high together with wr_en.
module adc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [RES_W-1:0] data,
    input  logic             wr_en,
    input  logic             rd,
    output logic [RES_W-1:0] result,
    output logic             flag
);
    // Capture the value on an accepted done.
    always_ff @(posedge clk) begin
        if (!rst_n)      result <= '0;
        else if (accept) result <= data;
    end

    // Set on accepted done (wins over read); clear on write or read.
    always_ff @(posedge clk) begin
        if (!rst_n)            flag <= 1'b0;
        else if (accept)       flag <= 1'b1;
        else if (wr_en || rd)  flag <= 1'b0;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// Conversion sequencer: latches the channel code of each write, drives the
// core's power, start and channel, captures results and decodes the channel.
// Assumes: the core samples core_chan while core_start is high and answers
// with a one-clock core_done.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W  = 5,
    parameter int RES_W   = 10,
    parameter int NUM_EXT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              wr_cont,
    input  logic              rd_result,
    input  logic              core_done,
    input  logic [RES_W-1:0]  core_data,
    output logic              core_pwr_en,
    output logic              core_start,
    output logic [CHAN_W-1:0] core_chan,
    output logic [RES_W-1:0]  result,
    output logic              conv_flag,
    output logic [2:0]        chan_kind
);
    localparam logic [CHAN_W-1:0] OFF_CODE = {CHAN_W{1'b1}};

    logic              wr_off;
    logic              accept;
    seq_state_t        state;
    logic              cont;
    chan_kind_t        kind;
    logic              lat_off;
    logic [CHAN_W-1:0] chan_q;

    assign wr_off = (wr_chan == OFF_CODE);

    // Channel latch: loaded by every write, parked at the off code in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     chan_q <= OFF_CODE;
        else if (wr_en) chan_q <= wr_chan;
    end

    adc_chan_decode #(
        .CHAN_W (CHAN_W),
        .NUM_EXT(NUM_EXT)
    ) u_decode (
        .code  (chan_q),
        .kind  (kind),
        .is_off(lat_off)
    );

    adc_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_off (wr_off),
        .wr_cont(wr_cont),
        .done   (core_done),
        .pwr_en (core_pwr_en),
        .start  (core_start),
        .accept (accept),
        .state  (state),
        .cont   (cont)
    );

    adc_result_reg #(
        .RES_W(RES_W)
    ) u_result (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .data  (core_data),
        .wr_en (wr_en),
        .rd    (rd_result),
        .result(result),
        .flag  (conv_flag)
    );

    assign core_chan = chan_q;
    assign chan_kind = lat_off ? KIND_OFF : kind;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Module: adc_seq_ctrl_chk
// Protocol checker for adc_seq_ctrl, bound to every instance of the top.
// Assumes: it sees the top's ports plus its sequencer state and repeat bit.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 5,
    parameter int RES_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CHAN_W-1:0] wr_chan,
    input logic              rd_result,
    input logic              core_done,
    input logic [RES_W-1:0]  core_data,
    input logic              core_pwr_en,
    input logic              core_start,
    input logic [RES_W-1:0]  result,
    input logic              conv_flag,
    input seq_state_t        state,
    input logic              cont
);
    logic acc;
    assign acc = core_done && (state == ST_CONV) && !core_start && !wr_en;

    AST_START_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R2
    AST_PWR_LEADS_START: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(core_pwr_en)); // R2
    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_en |=> !core_start); // R3
    AST_SINGLE_POWERS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cont) |=> !core_pwr_en); // R3
    AST_REPEAT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cont) |=> (core_start && core_pwr_en)); // R4
    AST_OFF_WRITE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_chan)) |=> (!core_pwr_en && !core_start)); // R5
    AST_DONE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (conv_flag && result == $past(core_data))); // R6
    AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !conv_flag); // R7
    AST_ABORT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(&wr_chan)) |=> (core_pwr_en && !core_start)); // R8
    AST_STRAY_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && state != ST_CONV && !wr_en && !rd_result)
        |=> ($stable(result) && $stable(conv_flag))); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .CHAN_W(CHAN_W),
    .RES_W (RES_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .rd_result  (rd_result),
    .core_done  (core_done),
    .core_data  (core_data),
    .core_pwr_en(core_pwr_en),
    .core_start (core_start),
    .result     (result),
    .conv_flag  (conv_flag),
    .state      (state),
    .cont       (cont)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CW  = 5;
    localparam int RW  = 10;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          wr_en = 1'b0, wr_cont = 1'b0, rd_result = 1'b0, inj_done = 1'b0;
    logic [CW-1:0] wr_chan = '0;
    logic          core_done, core_pwr_en, core_start, conv_flag;
    logic [RW-1:0] core_data, result;
    logic [CW-1:0] core_chan;
    logic [2:0]    chan_kind;

    int n_chk = 0, n_fail = 0;
    bit done_all = 1'b0;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_cont(wr_cont), .rd_result(rd_result), .core_done(core_done),
        .core_data(core_data), .core_pwr_en(core_pwr_en), .core_start(core_start),
        .core_chan(core_chan), .result(result), .conv_flag(conv_flag),
        .chan_kind(chan_kind)
    );

    // Fixed-latency core model: a new start restarts the countdown.
    int           cnt;
    logic [4:0]   seq;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            seq <= '0;
        end else begin
            if (core_start)   cnt <= LAT;
            else if (cnt > 0) cnt <= cnt - 1;
            if (core_done)    seq <= seq + 5'd1;
        end
    end
    assign core_done = (cnt == 1) || inj_done;
    assign core_data = {core_chan, seq};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_kind(input int c);
        if (c < 6)                 return 3'd0;
        if (c == 26)               return 3'd1;
        if (c == 29)               return 3'd2;
        if (c == 30)               return 3'd3;
        if (c == 27 || c == 28)    return 3'd4;
        if (c == 31)               return 3'd6;
        return 3'd5;
    endfunction

    task automatic do_write(input int c, input logic cont);
        @(negedge clk);
        wr_en = 1'b1; wr_chan = CW'(c); wr_cont = cont;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One single-shot conversion, checked clock by clock from the write.
    task automatic single_conv(input int c);
        logic [RW-1:0] exp;
        do_write(c, 1'b0);
        chk("R2 pwr after write", core_pwr_en, 1);
        chk("R2 no start yet", core_start, 0);
        chk("R2 channel", core_chan, c);
        chk("R10 kind", chan_kind, exp_kind(c));
        chk("R7 write clears flag", conv_flag, 0);
        @(negedge clk);
        chk("R2 start pulse", core_start, 1);
        repeat (2) @(negedge clk);
        chk("R2 start one clock", core_start, 0);
        @(negedge clk);
        chk("R10 conversion runs", core_done, 1);
        exp = core_data;
        @(negedge clk);
        chk("R6 result", result, exp);
        chk("R6 flag", conv_flag, 1);
        chk("R3 power down", core_pwr_en, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 no more starts", core_start, 0);
        end
    endtask

    initial begin
        logic [RW-1:0] keep;
        repeat (3) @(negedge clk);
        chk("R1 pwr", core_pwr_en, 0);
        chk("R1 start", core_start, 0);
        chk("R1 flag", conv_flag, 0);
        chk("R1 result", result, 0);
        chk("R1 chan", core_chan, 31);
        chk("R1 kind", chan_kind, 6);
        rst_n = 1'b1;

        // Sweep every code as a single shot; the off code stays silent.
        for (int c = 0; c < 32; c++) begin
            if (c == 31) begin
                keep = result;
                do_write(31, 1'b0);
                chk("R5 off no power", core_pwr_en, 0);
                chk("R10 off kind", chan_kind, 6);
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    chk("R5 off no start", core_start, 0);
                end
                chk("R5 result kept", result, keep);
            end else begin
                single_conv(c);
            end
        end

        // Read clears the flag and keeps the value (R7).
        single_conv(2);
        keep = result;
        @(negedge clk); rd_result = 1'b1;
        @(negedge clk); rd_result = 1'b0;
        chk("R7 read clears flag", conv_flag, 0);
        chk("R7 read keeps result", result, keep);

        // Repeating mode: back-to-back restarts (R4).
        do_write(3, 1'b1);
        @(negedge clk);
        chk("R4 first start", core_start, 1);
        for (int k = 0; k < 3; k++) begin
            repeat (3) @(negedge clk);
            keep = core_data;
            @(negedge clk);
            chk("R4 result", result, keep);
            chk("R4 restart", core_start, 1);
            chk("R4 power held", core_pwr_en, 1);
        end
        // Shutdown mid-run: nothing trailing (R5).
        keep = result;
        do_write(31, 1'b0);
        chk("R5 power off", core_pwr_en, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R5 no trailing start", core_start, 0);
        end
        chk("R5 no trailing result", result, keep);

        // Repeat run cut by a single-shot write mid-conversion (R8).
        do_write(7, 1'b1);
        @(negedge clk);
        chk("R8 repeat start", core_start, 1);
        single_conv(4);
        chk("R8 result from new channel", result[RW-1:5], 4);

        // Read and done in the same clock: flag set wins (R7).
        do_write(5, 1'b1);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 done visible", core_done, 1);
        rd_result = 1'b1;
        @(negedge clk);
        rd_result = 1'b0;
        chk("R7 set beats read", conv_flag, 1);
        do_write(31, 1'b0);
        chk("R7 off write clears", conv_flag, 0);

        // Stray done while idle is ignored (R9).
        keep = result;
        @(negedge clk); inj_done = 1'b1;
        @(negedge clk); inj_done = 1'b0;
        chk("R9 result kept", result, keep);
        chk("R9 flag kept", conv_flag, 0);

        // Stray done during the power-up clock is ignored (R9).
        do_write(1, 1'b0);
        inj_done = 1'b1;
        @(negedge clk); inj_done = 1'b0;
        chk("R9 pwrup done ignored flag", conv_flag, 0);
        chk("R9 pwrup done ignored result", result, keep);
        repeat (8) @(negedge clk);
        chk("R9 later real result", result[RW-1:5], 1);

        done_all = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_all) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule